// File: doc/BRIEF.md
# Double-Buffered PWM Channel Core

One output channel of a pulse-width modulator. A prescaler divides the module clock by a power of two. The divided tick drives a period counter. A compare against a live duty value sets the output level. Every period opens at the inactive level. The duty value gives the number of inactive ticks at the head of the period, and the output is active for the remaining ticks. A polarity input picks which logic level counts as active.

Software-side logic supplies the base period and duty values, which the channel captures when it starts. A single update port changes these values while the channel runs. Each write is held in one pending slot, and a target bit says whether the write is meant for the period or for the duty. The pending value is copied into the live register only at a period boundary, so no period is ever cut short or stretched by a write. Prescale, polarity and the base values are captured while the channel is stopped and frozen while it runs.

When the enable level falls, the channel finishes the period in progress. It then stops, drops its running flag and parks the output at the inactive level. A one-clock pulse marks the last clock of every period. That same clock is the boundary at which pending updates are committed.

Top module: `pwm_chan_core`

## Requirements
- R1: While reset is asserted and after its release with enable low, `pwm_o`, `per_end_o` and `running_o` are 0 (default polarity 0).
- R2: A period lasts max(period,1) * 2^p module clocks, where p is the prescale selector; a selector above 10 is treated as 10.
- R3: After a start the counter begins at zero. In each period the output is inactive for the first `duty` ticks and active for the remaining `period - duty` ticks.
- R4: With duty >= period the output is inactive for the whole period; with duty = 0 (and period > 0) it is active for the whole period.
- R5: With polarity 0 the active level is 1; with polarity 1 the waveform is inverted. While stopped, the output equals the polarity input registered one clock earlier.
- R6: `per_end_o` is high for exactly the last clock of each period and only while running.
- R7: An update write is not applied in the current period. It is committed at the next boundary at which the channel continues. Target bit 0 selects duty and target bit 1 selects period, and a later write before the boundary replaces an earlier one.
- R8: An update written on the same clock as a period end is not committed at that boundary; it is held for the following one.
- R9: When enable falls, `running_o` stays high until the end of the current period, including its period-end pulse. The output is then at the inactive level.
- R10: An update pending when the channel starts replaces the matching base value for the first period.
- R11: Changes to prescale, polarity, base period and base duty while running have no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req_i | input | 1 | Enable level; rise starts, fall stops at period end |
| pre_sel_i | input | PRE_W | Prescale exponent, clamped to PRE_MAX |
| pol_inv_i | input | 1 | Polarity: 1 inverts the waveform |
| cfg_prd_i | input | CNT_W | Base period in ticks, captured at start |
| cfg_dty_i | input | CNT_W | Base inactive tick count, captured at start |
| upd_wr_i | input | 1 | Update write strobe |
| upd_tgt_i | input | 1 | Update target: 0 duty, 1 period |
| upd_val_i | input | CNT_W | Update value |
| pwm_o | output | 1 | Waveform |
| per_end_o | output | 1 | Pulse on the last clock of each period |
| running_o | output | 1 | High while the channel is generating periods |

## Verification
Two functions can fall on the same clock: an update write and the period-end commit, and likewise a disable request and a period end. The bench issues an update write on the exact clock where `per_end_o` is high. It then checks that the next period keeps the old values and that the period after it carries the new ones. Enable is dropped in the middle of a period, and the bench checks that the period still runs to full length and that the running flag falls only after the last clock of that period.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  // Destination of a value written through the update port
  typedef enum logic {
    TGT_DUTY   = 1'b0,
    TGT_PERIOD = 1'b1
  } upd_tgt_e;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  localparam int DIV_W = (PRE_MAX < 1) ? 1 : PRE_MAX;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] lim;

  // terminal count: 2^pre - 1
  always_comb begin
    lim    = ~({DIV_W{1'b1}} << pre_i);
    tick_o = run_i & (div_q == lim);
  end

  always_comb begin
    div_d = div_q;
    if (start_i || !run_i) begin
      div_d = '0;
    end else if (tick_o) begin
      div_d = '0;
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic [CNT_W-1:0] dty_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             act_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   nxt_ext;
  logic             last_tick;

  always_comb begin
    nxt_ext   = {1'b0, cnt_q} + (CNT_W+1)'(1);
    last_tick = (nxt_ext >= {1'b0, prd_i});
    wrap_o    = tick_i & last_tick;
    act_o     = run_i & (dty_i < prd_i) & (cnt_q >= dty_i);
    cnt_o     = cnt_q;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = wrap_o ? '0 : nxt_ext[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             commit_i,
  input  logic             upd_wr_i,
  input  logic             upd_tgt_i,
  input  logic [CNT_W-1:0] upd_val_i,
  input  logic [CNT_W-1:0] cfg_prd_i,
  input  logic [CNT_W-1:0] cfg_dty_i,
  output logic [CNT_W-1:0] prd_o,
  output logic [CNT_W-1:0] dty_o
);
  logic [CNT_W-1:0] prd_q, prd_d;
  logic [CNT_W-1:0] dty_q, dty_d;
  logic             pv_q, pv_d;
  upd_tgt_e         pt_q, pt_d;
  logic [CNT_W-1:0] pval_q, pval_d;

  always_comb begin
    prd_d  = prd_q;
    dty_d  = dty_q;
    pv_d   = pv_q;
    pt_d   = pt_q;
    pval_d = pval_q;
    if (start_i) begin
      prd_d = (pv_q && pt_q == TGT_PERIOD) ? pval_q : cfg_prd_i;
      dty_d = (pv_q && pt_q == TGT_DUTY)   ? pval_q : cfg_dty_i;
    end else if (commit_i && pv_q) begin
      if (pt_q == TGT_PERIOD) begin
        prd_d = pval_q;
      end else begin
        dty_d = pval_q;
      end
    end
    if (start_i || commit_i) begin
      pv_d = 1'b0;
    end
    // a write on a boundary clock lands after that boundary
    if (upd_wr_i) begin
      pv_d   = 1'b1;
      pt_d   = upd_tgt_e'(upd_tgt_i);
      pval_d = upd_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_q  <= '0;
      dty_q  <= '0;
      pv_q   <= 1'b0;
      pt_q   <= TGT_DUTY;
      pval_q <= '0;
    end else begin
      prd_q  <= prd_d;
      dty_q  <= dty_d;
      pv_q   <= pv_d;
      pt_q   <= pt_d;
      pval_q <= pval_d;
    end
  end

  assign prd_o = prd_q;
  assign dty_o = dty_q;
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req_i,
  input  logic [PRE_W-1:0] pre_sel_i,
  input  logic             pol_inv_i,
  input  logic [CNT_W-1:0] cfg_prd_i,
  input  logic [CNT_W-1:0] cfg_dty_i,
  input  logic             upd_wr_i,
  input  logic             upd_tgt_i,
  input  logic [CNT_W-1:0] upd_val_i,
  output logic             pwm_o,
  output logic             per_end_o,
  output logic             running_o
);
  localparam logic [PRE_W-1:0] PRE_CAP = PRE_W'(PRE_MAX);

  logic             running_q, running_d;
  logic [PRE_W-1:0] pre_q, pre_clamped;
  logic             pol_q;
  logic             cfg_en;
  logic             start_w, commit_w;
  logic             tick_w, wrap_w, act_w;
  logic [CNT_W-1:0] prd_w, dty_w, cnt_w;

  always_comb begin
    pre_clamped = (pre_sel_i > PRE_CAP) ? PRE_CAP : pre_sel_i;
    cfg_en      = ~running_q;
    start_w     = run_req_i & ~running_q;
    commit_w    = wrap_w & run_req_i;
    running_d   = running_q;
    if (start_w) begin
      running_d = 1'b1;
    end else if (running_q && wrap_w && !run_req_i) begin
      running_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      pre_q     <= '0;
      pol_q     <= 1'b0;
    end else begin
      running_q <= running_d;
      if (cfg_en) begin
        pre_q <= pre_clamped;
        pol_q <= pol_inv_i;
      end
    end
  end

  pwm_prescaler #(.PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (running_q),
    .start_i (start_w),
    .pre_i   (pre_q),
    .tick_o  (tick_w)
  );

  pwm_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_w),
    .commit_i  (commit_w),
    .upd_wr_i  (upd_wr_i),
    .upd_tgt_i (upd_tgt_i),
    .upd_val_i (upd_val_i),
    .cfg_prd_i (cfg_prd_i),
    .cfg_dty_i (cfg_dty_i),
    .prd_o     (prd_w),
    .dty_o     (dty_w)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (running_q),
    .start_i (start_w),
    .tick_i  (tick_w),
    .prd_i   (prd_w),
    .dty_i   (dty_w),
    .cnt_o   (cnt_w),
    .wrap_o  (wrap_w),
    .act_o   (act_w)
  );

  assign pwm_o     = act_w ^ pol_q;
  assign per_end_o = wrap_w;
  assign running_o = running_q;
endmodule

// File: rtl/pwm_chan_core_chk.sv
module pwm_chan_core_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_req_i,
  input logic             pol_inv_i,
  input logic             pwm_o,
  input logic             per_end_o,
  input logic             running_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] prd_i,
  input logic [CNT_W-1:0] dty_i,
  input logic             pol_q_i
);
  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    per_end_o |-> running_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !per_end_o) |=> running_o);

  assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_o) |-> $past(per_end_o && !run_req_i));

  assert_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && cnt_i == '0 && dty_i != '0) |-> (pwm_o == pol_q_i));

  assert_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !per_end_o) |=> ($stable(prd_i) && $stable(dty_i)));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && $past(!running_o)) |-> (pwm_o == $past(pol_inv_i)));
endmodule

bind pwm_chan_core pwm_chan_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_req_i (run_req_i),
  .pol_inv_i (pol_inv_i),
  .pwm_o     (pwm_o),
  .per_end_o (per_end_o),
  .running_o (running_o),
  .cnt_i     (cnt_w),
  .prd_i     (prd_w),
  .dty_i     (dty_w),
  .pol_q_i   (pol_q)
);

// File: tb/pwm_chan_core_tb.sv
module pwm_chan_core_tb;
  logic        clk;
  logic        rst_n;
  logic        run_req;
  logic [3:0]  pre_sel;
  logic        pol;
  logic [15:0] cfg_prd;
  logic [15:0] cfg_dty;
  logic        upd_wr;
  logic        upd_tgt;
  logic [15:0] upd_val;
  logic        pwm;
  logic        per_end;
  logic        running;

  int checks = 0;
  int fails  = 0;
  logic cur_pol = 1'b0;

  pwm_chan_core u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_req_i (run_req),
    .pre_sel_i (pre_sel),
    .pol_inv_i (pol),
    .cfg_prd_i (cfg_prd),
    .cfg_dty_i (cfg_dty),
    .upd_wr_i  (upd_wr),
    .upd_tgt_i (upd_tgt),
    .upd_val_i (upd_val),
    .pwm_o     (pwm),
    .per_end_o (per_end),
    .running_o (running)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // columns: pre, pol, period, duty, expected clocks, expected active clocks
  localparam int VT [9][6] = '{
    '{ 0, 0, 10, 4,   10,    6},
    '{ 1, 0,  8, 2,   16,   12},
    '{ 2, 1,  5, 1,   20,   16},
    '{ 0, 0,  6, 6,    6,    0},
    '{ 0, 0,  6, 9,    6,    0},
    '{ 0, 1,  7, 0,    7,    7},
    '{15, 0,  2, 1, 2048, 1024},
    '{10, 0,  1, 0, 1024, 1024},
    '{ 0, 0,  0, 0,    1,    0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at the negedge of a period's first clock; returns at the
  // negedge of the next period's first clock.
  task automatic measure(input int wr_at, input logic wtgt, input int wval,
                         input logic stop, output int len, output int act,
                         output logic first_lvl);
    len = 0;
    act = 0;
    first_lvl = pwm;
    for (int k = 0; k < 5000; k++) begin
      upd_wr  = (k == wr_at);
      upd_tgt = wtgt;
      upd_val = 16'(wval);
      len++;
      if (pwm != cur_pol) act++;
      if (per_end) begin
        if (stop) run_req = 1'b0;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    upd_wr = 1'b0;
  endtask

  int   len, act;
  logic fl;

  initial begin
    rst_n = 1'b0; run_req = 1'b0; pre_sel = 4'd0; pol = 1'b0;
    cfg_prd = 16'd0; cfg_dty = 16'd0; upd_wr = 1'b0; upd_tgt = 1'b0; upd_val = 16'd0;
    repeat (3) @(negedge clk);
    chk("R1 out in reset", int'(pwm), 0);
    chk("R1 running in reset", int'(running), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 per_end after reset", int'(per_end), 0);
    chk("R1 out after reset", int'(pwm), 0);

    // table-driven waveform vectors
    for (int v = 0; v < 9; v++) begin
      pre_sel = 4'(VT[v][0]); pol = VT[v][1][0]; cur_pol = VT[v][1][0];
      cfg_prd = 16'(VT[v][2]); cfg_dty = 16'(VT[v][3]);
      @(negedge clk);
      chk("R5 idle level follows polarity", int'(pwm), VT[v][1]);
      run_req = 1'b1;
      @(negedge clk);
      chk("R9 running after start", int'(running), 1);
      measure(-1, 1'b0, 0, 1'b1, len, act, fl);
      chk("R2 period clocks", len, VT[v][4]);
      chk("R3 R4 active clocks", act, VT[v][5]);
      if (VT[v][3] != 0 || VT[v][2] == 0)
        chk("R3 period opens inactive", int'(fl), VT[v][1]);
      chk("R6 stopped after boundary", int'(running), 0);
      chk("R6 no pulse when stopped", int'(per_end), 0);
    end

    // R7 / R8: update steering and boundary collision
    pre_sel = 4'd0; pol = 1'b0; cur_pol = 1'b0; cfg_prd = 16'd10; cfg_dty = 16'd4;
    @(negedge clk);
    run_req = 1'b1;
    @(negedge clk);
    measure(3, 1'b0, 8, 1'b0, len, act, fl);
    chk("R7 duty write not immediate", act, 6);
    measure(-1, 1'b0, 0, 1'b0, len, act, fl);
    chk("R7 duty applied after boundary", act, 2);
    measure(9, 1'b1, 14, 1'b0, len, act, fl);
    chk("R8 write on boundary clock, len", len, 10);
    measure(-1, 1'b0, 0, 1'b0, len, act, fl);
    chk("R8 held past coincident boundary", len, 10);
    measure(-1, 1'b0, 0, 1'b1, len, act, fl);
    chk("R7 period applied, len", len, 14);
    chk("R7 period applied, active", act, 6);

    // R9: disable mid-period
    cfg_prd = 16'd10; cfg_dty = 16'd0;
    @(negedge clk);
    run_req = 1'b1;
    @(negedge clk);
    measure(-1, 1'b0, 0, 1'b0, len, act, fl);
    repeat (2) @(negedge clk);
    run_req = 1'b0;
    len = 0; act = 0;
    for (int k = 0; k < 100 && running; k++) begin
      len++;
      if (per_end) act++;
      @(negedge clk);
    end
    chk("R9 running held to period end", len, 8);
    chk("R9 single period-end pulse seen", act, 1);
    chk("R9 output idle after stop", int'(pwm), 0);

    // R10: pending update applied at start; R11: frozen settings
    upd_wr = 1'b1; upd_tgt = 1'b1; upd_val = 16'd4;
    @(negedge clk);
    upd_wr = 1'b0;
    cfg_prd = 16'd10; cfg_dty = 16'd1;
    @(negedge clk);
    run_req = 1'b1;
    @(negedge clk);
    measure(-1, 1'b0, 0, 1'b0, len, act, fl);
    chk("R10 pending period used at start", len, 4);
    chk("R10 base duty kept", act, 3);
    pre_sel = 4'd3; pol = 1'b1; cfg_prd = 16'd20; cfg_dty = 16'd0;
    measure(-1, 1'b0, 0, 1'b1, len, act, fl);
    chk("R11 period unchanged while running", len, 4);
    chk("R11 duty/polarity unchanged", act, 3);
    chk("R11 old polarity at stop clock", int'(pwm), 0);
    @(negedge clk);
    chk("R5 new polarity once idle", int'(pwm), 1);
    pol = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule